// File: doc/BRIEF.md
# Relative operand address normaliser

This block sits between instruction fetch and execute in a core that addresses a circular memory only by relative offsets. On a start pulse it takes the fetched instruction's two operand fields, their two-bit mode codes and the program counter. It turns each operand into either literal data or an absolute core address. Indirect forms read the B-field of an intermediate location through a request/acknowledge memory port. The predecrementing form also writes a reduced value back to that location.

The A operand is finished, including any write-back, before the B operand starts. A side effect caused by A is therefore always visible to B. All sums and the decrement wrap modulo the core size, which need not be a power of two. When both operands are settled, a single-cycle done strobe marks the moment the two values and their literal flags are updated. The outputs then hold until the next completion.

Top module: `nrm_operand_norm`

## Requirements
- R1: Mode code 0 is immediate. The operand's output value equals its field, its literal flag is 1, and it causes no memory access.
- R2: Mode code 1 is direct. The output is (pc + field) mod CORE_SIZE, the literal flag is 0, and there is no memory access.
- R3: Mode code 2 is indirect. One read fetches the B-field at ptr = (pc + field) mod CORE_SIZE, and the output is (ptr + read value) mod CORE_SIZE. No write is made.
- R4: Mode code 3 is predecrement. One read at ptr is followed by one write of (read value - 1) mod CORE_SIZE to ptr, so 0 becomes CORE_SIZE-1. The output is (ptr + written value) mod CORE_SIZE.
- R5: Every memory access of the A operand completes before the first access of the B operand. A location decremented by A is therefore seen decremented by B.
- R6: A direct field of 0 yields the program counter itself.
- R7: done is high for exactly one cycle after each start. The four outputs change only in the cycle done is high, and done is never high while a memory request is pending.
- R8: mem_req stays high with mem_addr, mem_we and mem_wdata stable until mem_ack is seen, however many cycles the acknowledge takes.
- R9: After reset, done and mem_req are 0 and both output values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin normalising the presented instruction (taken when idle) |
| pc | input | AW | Program counter of the instruction |
| a_mode | input | 2 | A operand mode: 0 immediate, 1 direct, 2 indirect, 3 predecrement |
| a_field | input | AW | A operand field |
| b_mode | input | 2 | B operand mode, same coding |
| b_field | input | AW | B operand field |
| mem_req | output | 1 | Core access request, held until acknowledged |
| mem_we | output | 1 | 1 for a B-field write, 0 for a B-field read |
| mem_addr | output | AW | Absolute core address of the access |
| mem_wdata | output | AW | B-field value to write |
| mem_ack | input | 1 | Access completed; read data valid in this cycle |
| mem_rdata | input | AW | B-field read from mem_addr |
| done | output | 1 | Both operands resolved (one cycle) |
| a_is_imm | output | 1 | A result is literal data |
| a_value | output | AW | A result: data or absolute address |
| b_is_imm | output | 1 | B result is literal data |
| b_value | output | AW | B result: data or absolute address |

## Verification
The bench builds the block with CORE_SIZE = 40 and AW = 6. Because this size is not a power of two, the compare-and-subtract variant of the wrap adder is exercised. Any pc near 39 reaches the wrap, and a stored B-field of 0 exercises the decrement wrap to 39. A small model memory with an adjustable acknowledge delay lets back-to-back predecrements on the same cell show the ordering between the two operands. The same model exercises long request waits.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
   typedef enum logic [1:0] {
      MODE_IMM  = 2'd0,
      MODE_DIR  = 2'd1,
      MODE_IND  = 2'd2,
      MODE_PDEC = 2'd3
   } mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVAL,
      ST_RD,
      ST_WR,
      ST_DONE
   } state_e;
endpackage

// File: rtl/nrm_modadd.sv
module nrm_modadd #(
   parameter int unsigned SIZE = 8000,
   parameter int unsigned AW   = 13
) (
   input  logic [AW-1:0] x,
   input  logic [AW-1:0] y,
   output logic [AW-1:0] s
);
   localparam bit POW2 = (SIZE == (64'd1 << AW));

   generate
      if (POW2) begin : g_pow2
         assign s = x + y;
      end else begin : g_general
         localparam logic [AW:0] LIM = (AW+1)'(SIZE);
         logic [AW:0] raw;
         logic [AW:0] red;
         assign raw = {1'b0, x} + {1'b0, y};
         assign red = raw - LIM;
         assign s   = (raw >= LIM) ? red[AW-1:0] : raw[AW-1:0];
      end
   endgenerate
endmodule

// File: rtl/nrm_ctrl.sv
module nrm_ctrl
   import nrm_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  mode_e  cur_mode,
   input  logic   mem_ack,
   output state_e state,
   output logic   side,
   output logic   fin
);
   state_e nxt;

   always_comb begin
      fin = 1'b0;
      unique case (state)
         ST_EVAL: fin = (cur_mode == MODE_IMM) || (cur_mode == MODE_DIR);
         ST_RD:   fin = mem_ack && (cur_mode != MODE_PDEC);
         ST_WR:   fin = mem_ack;
         default: fin = 1'b0;
      endcase
   end

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (start) nxt = ST_EVAL;
         ST_EVAL: begin
            if (!fin)     nxt = ST_RD;
            else if (side) nxt = ST_DONE;
            else          nxt = ST_EVAL;
         end
         ST_RD: begin
            if (mem_ack) begin
               if (cur_mode == MODE_PDEC) nxt = ST_WR;
               else                       nxt = side ? ST_DONE : ST_EVAL;
            end
         end
         ST_WR:   if (mem_ack) nxt = side ? ST_DONE : ST_EVAL;
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         side  <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_IDLE && start) side <= 1'b0;
         else if (fin && !side)         side <= 1'b1;
      end
   end
endmodule

// File: rtl/nrm_operand_norm.sv
module nrm_operand_norm
   import nrm_pkg::*;
#(
   parameter int unsigned CORE_SIZE = 8000,
   parameter int unsigned AW        = $clog2(CORE_SIZE)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] pc,
   input  logic [1:0]    a_mode,
   input  logic [AW-1:0] a_field,
   input  logic [1:0]    b_mode,
   input  logic [AW-1:0] b_field,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [AW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [AW-1:0] mem_rdata,
   output logic          done,
   output logic          a_is_imm,
   output logic [AW-1:0] a_value,
   output logic          b_is_imm,
   output logic [AW-1:0] b_value
);
   localparam logic [AW-1:0] MINUS_ONE = AW'(CORE_SIZE - 1);

   generate
      if (CORE_SIZE < 2 || (64'd1 << AW) < CORE_SIZE) begin : g_bad_size
         $error("nrm_operand_norm: AW too small for CORE_SIZE, or CORE_SIZE below 2");
      end
   endgenerate

   state_e        state;
   logic          side;
   logic          fin;
   mode_e         cur_mode;
   logic [AW-1:0] cur_val;

   logic [AW-1:0] pc_q, a_val_q, b_val_q;
   mode_e         a_mode_q, b_mode_q;
   logic [AW-1:0] ptr_q, dec_q;
   logic [AW-1:0] a_hold;
   logic          a_imm_hold;

   logic [AW-1:0] add_x, add_y, sum, dec;
   logic          imm_now;
   logic [AW-1:0] res;

   assign cur_mode = side ? b_mode_q : a_mode_q;
   assign cur_val  = side ? b_val_q  : a_val_q;

   nrm_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cur_mode (cur_mode),
      .mem_ack  (mem_ack),
      .state    (state),
      .side     (side),
      .fin      (fin)
   );

   always_comb begin
      unique case (state)
         ST_EVAL: begin add_x = pc_q;  add_y = cur_val;   end
         ST_RD:   begin add_x = ptr_q; add_y = mem_rdata; end
         default: begin add_x = ptr_q; add_y = dec_q;     end
      endcase
   end

   nrm_modadd #(.SIZE(CORE_SIZE), .AW(AW)) u_addr_add (
      .x (add_x),
      .y (add_y),
      .s (sum)
   );

   nrm_modadd #(.SIZE(CORE_SIZE), .AW(AW)) u_dec_add (
      .x (mem_rdata),
      .y (MINUS_ONE),
      .s (dec)
   );

   assign imm_now = (state == ST_EVAL) && (cur_mode == MODE_IMM);
   assign res     = imm_now ? cur_val : sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q       <= '0;
         a_val_q    <= '0;
         b_val_q    <= '0;
         a_mode_q   <= MODE_IMM;
         b_mode_q   <= MODE_IMM;
         ptr_q      <= '0;
         dec_q      <= '0;
         a_hold     <= '0;
         a_imm_hold <= 1'b0;
         a_value    <= '0;
         a_is_imm   <= 1'b0;
         b_value    <= '0;
         b_is_imm   <= 1'b0;
      end else begin
         if (state == ST_IDLE && start) begin
            pc_q     <= pc;
            a_val_q  <= a_field;
            b_val_q  <= b_field;
            a_mode_q <= mode_e'(a_mode);
            b_mode_q <= mode_e'(b_mode);
         end
         if (state == ST_EVAL && !fin)
            ptr_q <= sum;
         if (state == ST_RD && mem_ack && cur_mode == MODE_PDEC)
            dec_q <= dec;
         if (fin) begin
            if (!side) begin
               a_hold     <= res;
               a_imm_hold <= imm_now;
            end else begin
               b_value  <= res;
               b_is_imm <= imm_now;
               a_value  <= a_hold;
               a_is_imm <= a_imm_hold;
            end
         end
      end
   end

   assign mem_req   = (state == ST_RD) || (state == ST_WR);
   assign mem_we    = (state == ST_WR);
   assign mem_addr  = ptr_q;
   assign mem_wdata = dec_q;
   assign done      = (state == ST_DONE);
endmodule

// File: rtl/nrm_operand_norm_chk.sv
module nrm_operand_norm_chk #(
   parameter int unsigned AW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] mem_wdata,
   input logic          mem_ack,
   input logic          done,
   input logic          a_is_imm,
   input logic [AW-1:0] a_value,
   input logic          b_is_imm,
   input logic [AW-1:0] b_value
);
   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(a_value) && $stable(b_value) && $stable(a_is_imm) && $stable(b_is_imm)));

   // R4
   write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !$past(mem_req && mem_we)) |-> $past(mem_req && mem_ack && !mem_we));
endmodule

bind nrm_operand_norm nrm_operand_norm_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .done      (done),
   .a_is_imm  (a_is_imm),
   .a_value   (a_value),
   .b_is_imm  (b_is_imm),
   .b_value   (b_value)
);

// File: tb/nrm_operand_norm_test.sv
`timescale 1ns/100ps
module nrm_operand_norm_test;
   localparam int CS = 40;
   localparam int AW = 6;
   localparam int NV = 8;

   // pc, a_mode, a_field, b_mode, b_field
   localparam logic [21:0] VEC [NV] = '{
      {6'd5,  2'd0, 6'd7,  2'd1, 6'd3},
      {6'd0,  2'd1, 6'd0,  2'd0, 6'd39},
      {6'd38, 2'd1, 6'd5,  2'd2, 6'd4},
      {6'd10, 2'd2, 6'd30, 2'd3, 6'd1},
      {6'd20, 2'd3, 6'd2,  2'd2, 6'd2},
      {6'd20, 2'd3, 6'd2,  2'd3, 6'd2},
      {6'd39, 2'd3, 6'd1,  2'd1, 6'd39},
      {6'd7,  2'd0, 6'd0,  2'd0, 6'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] pc = '0, a_field = '0, b_field = '0;
   logic [1:0] a_mode = '0, b_mode = '0;
   logic mem_req, mem_we, done, a_is_imm, b_is_imm;
   logic [AW-1:0] mem_addr, mem_wdata, a_value, b_value;
   logic mem_ack = 1'b0;
   logic [AW-1:0] mem_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   nrm_operand_norm #(.CORE_SIZE(CS), .AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .pc(pc),
      .a_mode(a_mode), .a_field(a_field), .b_mode(b_mode), .b_field(b_field),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
      .a_is_imm(a_is_imm), .a_value(a_value), .b_is_imm(b_is_imm), .b_value(b_value)
   );

   // core model: B-field per cell, acknowledge after 'stall' extra cycles
   logic [AW-1:0] mem [CS];
   int ref_mem [CS];
   int stall = 0;
   int scnt = 0;
   int n_rd = 0;
   int n_wr = 0;

   initial begin
      for (int i = 0; i < CS; i++) begin
         mem[i]     = AW'((i * 7 + 3) % CS);
         ref_mem[i] = (i * 7 + 3) % CS;
      end
   end

   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         if (scnt >= stall) begin
            mem_ack <= 1'b1;
            scnt    <= 0;
            if (mem_we) begin
               mem[mem_addr] <= mem_wdata;
               n_wr <= n_wr + 1;
            end else begin
               mem_rdata <= mem[mem_addr];
               n_rd <= n_rd + 1;
            end
         end else begin
            scnt <= scnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   function automatic int madd(int x, int y);
      return (x + y) % CS;
   endfunction

   task automatic chk(string tag, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic ref_side(input int md, input int val, input int p,
                           output int imm, output int res, inout int rd, inout int wr);
      int ptr;
      int d;
      imm = 0;
      ptr = madd(p, val);
      case (md)
         0: begin imm = 1; res = val; end
         1: res = ptr;
         2: begin rd++; res = madd(ptr, ref_mem[ptr]); end
         default: begin
            rd++;
            d = (ref_mem[ptr] + CS - 1) % CS;
            ref_mem[ptr] = d;
            wr++;
            res = madd(ptr, d);
         end
      endcase
   endtask

   task automatic run_vec(input logic [21:0] v, input string tag);
      int ea_imm, ea_val, eb_imm, eb_val, erd, ewr, rd0, wr0, t, mism;
      erd = 0; ewr = 0;
      ref_side(int'(v[15:14]), int'(v[13:8]), int'(v[21:16]), ea_imm, ea_val, erd, ewr);
      ref_side(int'(v[7:6]),   int'(v[5:0]),  int'(v[21:16]), eb_imm, eb_val, erd, ewr);
      rd0 = n_rd; wr0 = n_wr;
      @(negedge clk);
      pc = v[21:16]; a_mode = v[15:14]; a_field = v[13:8];
      b_mode = v[7:6]; b_field = v[5:0]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done && t < 300) begin @(negedge clk); t++; end
      chk("R7", int'(done), 1, {tag, " done seen"});
      chk("R1/R2/R3/R4", int'(a_is_imm), ea_imm, {tag, " a_is_imm"});
      chk("R1/R2/R3/R4", int'(a_value),  ea_val, {tag, " a_value"});
      chk("R1/R2/R3/R4", int'(b_is_imm), eb_imm, {tag, " b_is_imm"});
      chk("R1/R2/R3/R4", int'(b_value),  eb_val, {tag, " b_value"});
      chk("R1 R3", n_rd - rd0, erd, {tag, " read count"});
      chk("R4", n_wr - wr0, ewr, {tag, " write count"});
      mism = 0;
      for (int i = 0; i < CS; i++) if (int'(mem[i]) != ref_mem[i]) mism++;
      chk("R4 R5", mism, 0, {tag, " memory image mismatches"});
      @(negedge clk);
      chk("R7", int'(done), 0, {tag, " done one cycle"});
      chk("R7", int'(b_value), eb_val, {tag, " b_value held"});
   endtask

   initial begin
      #(100000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", int'(done), 0, "done after reset");
      chk("R9", int'(mem_req), 0, "mem_req after reset");
      chk("R9", int'(a_value) + int'(b_value), 0, "values after reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", int'(mem_req), 0, "mem_req idle after release");

      for (int k = 0; k < NV; k++) begin
         run_vec(VEC[k], $sformatf("vec%0d", k));
         if (k == 3) chk("R4", int'(b_value), 10, "decrement of 0 wraps to 39");
         if (k == 4) begin
            chk("R5", int'(a_value), 18, "A predecrement result");
            chk("R5", int'(b_value), 18, "B sees A decrement");
         end
      end

      // R6 direct field 0 is the instruction itself
      run_vec({6'd17, 2'd1, 6'd0, 2'd1, 6'd0}, "self");
      chk("R6", int'(a_value), 17, "direct 0 gives pc");

      // R8 slow acknowledge
      stall = 3;
      run_vec({6'd20, 2'd3, 6'd2, 2'd3, 6'd2}, "stall3");
      stall = 5;
      run_vec({6'd33, 2'd2, 6'd9, 2'd3, 6'd7}, "stall5");
      stall = 0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule